// File: doc/BRIEF.md
# Power Mode Control Sequencer

This block decides which low-power mode a small microcontroller-based device enters and walks it into that mode. Software raises a power-down request bit. The block does not act on that bit at once. It holds the request for a fixed number of core clocks and then raises an internal power-down signal. At that point it picks one of two modes. In standby the core and its clocked peripherals stop while the main rail stays up. In full OFF the step-up converter is disabled, so the main rail collapses.

The mode depends on the bus-supply flag and the ON/OFF switch level. Both are first passed through synchronizers, as are the battery and auxiliary supply flags. A present bus supply always wins: it forces standby rather than OFF, and it pulls the device out of OFF. A switch input held low counts as a permanent ON request.

While the power-down signal is high, a group of peripheral enables (supply-fault detector, analog comparator, high-speed oscillator, smart-card power, flash read one-shot) is forced off. When the signal is low, each enable follows its own control bit. The block also reports which supply is feeding the device. It places the converter in bypass when the bus supply is feeding the device and no smart-card supply is requested.

Top module: `pwr_mode_seq`

## Requirements
- R1: When `pdReq` rises just after a clock edge and stays high, `pdSignal` is still low after the 31st following rising edge and is high after the 32nd.
- R2: If `pdReq` is cleared before the count completes, `pdSignal` never rises, and a later request again waits the full 32 edges.
- R3: At the end of the count, if the synchronized bus flag is 1 or the synchronized `switchOff` is 0, the block enters standby: `standby`=1, `offState`=0, `convEn`=1.
- R4: At the end of the count, if the synchronized bus flag is 0 and the synchronized `switchOff` is 1, the block enters OFF: `offState`=1, `standby`=0, `convEn`=0, `convBypass`=0.
- R5: `srcSel` encodes the chosen supply by priority: 2'b01 bus, else 2'b10 battery, else 2'b11 auxiliary, else 2'b00 none. It uses synchronized flags, so it follows an input change after two rising edges.
- R6: `convBypass` is 1 exactly when the bus is selected, `cardSupplyReq` is 0 and the block is not in OFF.
- R7: While `pdSignal` is 1, `periphEn` is all zero. Otherwise `periphEn` equals `periphCtl` bit for bit (bit0 fault detector, bit1 comparator, bit2 fast oscillator, bit3 card power, bit4 flash one-shot).
- R8: In OFF, a bus-supply arrival or `switchOff` falling to 0 returns the block to run. `offState` and `pdSignal` are still 1 after the second rising edge following the input change and are 0 after the third.
- R9: In standby, clearing `pdReq` returns the block to run on the next rising edge (`pdSignal`=0, `standby`=0).
- R10: With `switchOff` tied low and only the battery present, a completed request gives standby, not OFF.
- R11: After reset, `pdSignal`, `standby`, `offState`, `convBypass` are 0, `convEn` is 1, `srcSel` is 2'b00.
- R12: Removing the bus supply while running switches `srcSel` to battery, and the block stays in run with `convEn`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pdReq | input | 1 | Software power-down request bit |
| busPresent | input | 1 | Bus supply present (asynchronous) |
| batPresent | input | 1 | Battery supply present (asynchronous) |
| auxPresent | input | 1 | Auxiliary supply present (asynchronous) |
| switchOff | input | 1 | Debounced switch level, 1 = OFF position, 0 = ON |
| cardSupplyReq | input | 1 | Smart-card supply demand |
| periphCtl | input | PERIPH_N | Per-peripheral enable control bits |
| pdSignal | output | 1 | Delayed internal power-down |
| standby | output | 1 | Standby mode active |
| offState | output | 1 | Full OFF mode active |
| convEn | output | 1 | Step-up converter enable |
| convBypass | output | 1 | Converter bypass select |
| srcSel | output | 2 | Selected supply code |
| periphEn | output | PERIPH_N | Gated peripheral enables |

## Verification
On every cycle, the checker confirms several relations:
- the gating of `periphEn` by `pdSignal`;
- that the converter is off and not bypassed in OFF;
- the bus-first priority of `srcSel` and the bypass condition, using inputs delayed through the synchronizer depth;
- that every rise of `pdSignal` follows exactly 32 cycles of continuous request;
- that the standby-or-OFF choice matches the supply and switch levels three cycles earlier;
- the one-clock exit from OFF on a bus arrival.

The scenarios alone show the exact edge counts seen at the ports: the abort and reload of the count, the exit from standby when the request is cleared, the tied-low switch case and bus removal during run.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PM_RUN     = 2'd0,
    PM_ARM     = 2'd1,
    PM_STANDBY = 2'd2,
    PM_OFF     = 2'd3
  } pmState_t;

  typedef struct packed {
    logic cntLoad;
    logic cntStep;
  } pmStrobe_t;

  localparam logic [1:0] SRC_NONE = 2'b00;
  localparam logic [1:0] SRC_BUS  = 2'b01;
  localparam logic [1:0] SRC_BAT  = 2'b10;
  localparam logic [1:0] SRC_AUX  = 2'b11;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= rawIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int DELAY       = 32,
  parameter int PERIPH_N    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  pmStrobe_t           strobe,
  input  logic                busPresent,
  input  logic                batPresent,
  input  logic                auxPresent,
  input  logic                switchOff,
  input  logic                cardSupplyReq,
  input  logic [PERIPH_N-1:0] periphCtl,
  input  logic                pdActive,
  input  logic                offActive,
  output logic                busOk,
  output logic                switchOffOk,
  output logic                cntDone,
  output logic [1:0]          srcSel,
  output logic                convBypass,
  output logic [PERIPH_N-1:0] periphEn
);
  localparam int CNT_W = $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY - 1);

  logic [3:0] syncVec;
  logic batOk, auxOk;
  logic [CNT_W-1:0] cnt;

  pwr_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({switchOff, auxPresent, batPresent, busPresent}),
    .syncOut (syncVec)
  );

  assign busOk       = syncVec[0];
  assign batOk       = syncVec[1];
  assign auxOk       = syncVec[2];
  assign switchOffOk = syncVec[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.cntLoad) cnt <= CNT_W'(1);
    else if (strobe.cntStep) cnt <= cnt + CNT_W'(1);
  end

  assign cntDone = (cnt == CNT_LAST);

  always_comb begin
    if (busOk)      srcSel = SRC_BUS;
    else if (batOk) srcSel = SRC_BAT;
    else if (auxOk) srcSel = SRC_AUX;
    else            srcSel = SRC_NONE;
  end

  assign convBypass = busOk & ~cardSupplyReq & ~offActive;
  assign periphEn   = periphCtl & ~{PERIPH_N{pdActive}};
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pdReq,
  input  logic      busOk,
  input  logic      switchOffOk,
  input  logic      cntDone,
  output pmStrobe_t strobe,
  output logic      pdSignal,
  output logic      standby,
  output logic      offState,
  output logic      convEn
);
  pmState_t state, stateNext;
  logic keepAlive;

  assign keepAlive = busOk | ~switchOffOk;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      PM_RUN: begin
        if (pdReq) begin
          strobe.cntLoad = 1'b1;
          stateNext      = PM_ARM;
        end
      end
      PM_ARM: begin
        if (!pdReq)       stateNext = PM_RUN;
        else if (cntDone) stateNext = keepAlive ? PM_STANDBY : PM_OFF;
        else              strobe.cntStep = 1'b1;
      end
      PM_STANDBY: if (!pdReq)    stateNext = PM_RUN;
      PM_OFF:     if (keepAlive) stateNext = PM_RUN;
      default:                   stateNext = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PM_RUN;
    else       state <= stateNext;
  end

  assign standby  = (state == PM_STANDBY);
  assign offState = (state == PM_OFF);
  assign pdSignal = standby | offState;
  assign convEn   = ~offState;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int DELAY       = 32,
  parameter int PERIPH_N    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pdReq,
  input  logic                busPresent,
  input  logic                batPresent,
  input  logic                auxPresent,
  input  logic                switchOff,
  input  logic                cardSupplyReq,
  input  logic [PERIPH_N-1:0] periphCtl,
  output logic                pdSignal,
  output logic                standby,
  output logic                offState,
  output logic                convEn,
  output logic                convBypass,
  output logic [1:0]          srcSel,
  output logic [PERIPH_N-1:0] periphEn
);
  pmStrobe_t strobe;
  logic busOk, switchOffOk, cntDone;

  pwr_mode_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .pdReq       (pdReq),
    .busOk       (busOk),
    .switchOffOk (switchOffOk),
    .cntDone     (cntDone),
    .strobe      (strobe),
    .pdSignal    (pdSignal),
    .standby     (standby),
    .offState    (offState),
    .convEn      (convEn)
  );

  pwr_mode_dp #(
    .DELAY(DELAY), .PERIPH_N(PERIPH_N), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .busPresent    (busPresent),
    .batPresent    (batPresent),
    .auxPresent    (auxPresent),
    .switchOff     (switchOff),
    .cardSupplyReq (cardSupplyReq),
    .periphCtl     (periphCtl),
    .pdActive      (pdSignal),
    .offActive     (offState),
    .busOk         (busOk),
    .switchOffOk   (switchOffOk),
    .cntDone       (cntDone),
    .srcSel        (srcSel),
    .convBypass    (convBypass),
    .periphEn      (periphEn)
  );
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
  parameter int DELAY    = 32,
  parameter int PERIPH_N = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                pdReq,
  input logic                busPresent,
  input logic                batPresent,
  input logic                switchOff,
  input logic                cardSupplyReq,
  input logic [PERIPH_N-1:0] periphCtl,
  input logic                pdSignal,
  input logic                standby,
  input logic                offState,
  input logic                convEn,
  input logic                convBypass,
  input logic [1:0]          srcSel,
  input logic [PERIPH_N-1:0] periphEn
);
  localparam int RUN_W = $clog2(DELAY + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic [RUN_W-1:0] reqRun;
  logic [2:0] warm;
  logic warmOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  reqRun <= '0;
    else if (!pdReq || pdSignal) reqRun <= '0;
    else if (reqRun != RUN_MAX) reqRun <= reqRun + RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           warm <= '0;
    else if (warm != 3'd7) warm <= warm + 3'd1;
  end
  assign warmOk = (warm >= 3'd4);

  assert_exact_delay_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdSignal) |-> (reqRun == RUN_W'(DELAY)));

  assert_mode_choice_R3: assert property (@(posedge clk) disable iff (!rstN)
    (warmOk && $rose(pdSignal)) |->
      (offState == (!$past(busPresent, 3) && $past(switchOff, 3))));

  assert_one_mode_R4: assert property (@(posedge clk) disable iff (!rstN)
    pdSignal |-> (standby ^ offState));

  assert_off_rail_R4: assert property (@(posedge clk) disable iff (!rstN)
    offState |-> (!convEn && !convBypass));

  assert_bus_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (warmOk && $past(busPresent, 2)) |-> (srcSel == 2'b01));

  assert_bat_second_R5: assert property (@(posedge clk) disable iff (!rstN)
    (warmOk && !$past(busPresent, 2) && $past(batPresent, 2)) |-> (srcSel == 2'b10));

  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rstN)
    convBypass |-> (srcSel == 2'b01 && !cardSupplyReq && !offState));

  assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    pdSignal |-> (periphEn == '0));

  assert_gate_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    !pdSignal |-> (periphEn == periphCtl));

  assert_bus_wake_R8: assert property (@(posedge clk) disable iff (!rstN)
    (warmOk && offState && $past(busPresent, 2)) |=> (!offState && !pdSignal));
endmodule

bind pwr_mode_seq pwr_mode_chk #(.DELAY(DELAY), .PERIPH_N(PERIPH_N)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .pdReq         (pdReq),
  .busPresent    (busPresent),
  .batPresent    (batPresent),
  .switchOff     (switchOff),
  .cardSupplyReq (cardSupplyReq),
  .periphCtl     (periphCtl),
  .pdSignal      (pdSignal),
  .standby       (standby),
  .offState      (offState),
  .convEn        (convEn),
  .convBypass    (convBypass),
  .srcSel        (srcSel),
  .periphEn      (periphEn)
);

// File: tb/tb_pwr_mode_seq.sv
`timescale 1ns/1ps
module tb_pwr_mode_seq;
  localparam int DELAY = 32;
  localparam int PN    = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdReq = 1'b0, busPresent = 1'b0, batPresent = 1'b0, auxPresent = 1'b0;
  logic switchOff = 1'b0, cardSupplyReq = 1'b0;
  logic [PN-1:0] periphCtl = '0;
  logic pdSignal, standby, offState, convEn, convBypass;
  logic [1:0] srcSel;
  logic [PN-1:0] periphEn;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pwr_mode_seq dut (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .busPresent(busPresent),
    .batPresent(batPresent), .auxPresent(auxPresent), .switchOff(switchOff),
    .cardSupplyReq(cardSupplyReq), .periphCtl(periphCtl), .pdSignal(pdSignal),
    .standby(standby), .offState(offState), .convEn(convEn),
    .convBypass(convBypass), .srcSel(srcSel), .periphEn(periphEn)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    pdReq = 1'b0;
    step(4);
  endtask

  task automatic tReset();
    check("R11 pdSignal", 8'(pdSignal), 8'd0);
    check("R11 standby", 8'(standby), 8'd0);
    check("R11 offState", 8'(offState), 8'd0);
    check("R11 convEn", 8'(convEn), 8'd1);
    check("R11 convBypass", 8'(convBypass), 8'd0);
    check("R11 srcSel", 8'(srcSel), 8'd0);
  endtask

  task automatic tDelay();
    busPresent = 1'b1; switchOff = 1'b1; step(4);
    pdReq = 1'b1;
    step(DELAY - 1);
    check("R1 low before count", 8'(pdSignal), 8'd0);
    step(1);
    check("R1 high at count", 8'(pdSignal), 8'd1);
    check("R3 standby with bus", 8'({standby, offState, convEn}), 8'b101);
    pdReq = 1'b0; step(1);
    check("R9 standby exit", 8'({pdSignal, standby}), 8'b00);
    settle();
  endtask

  task automatic tAbort();
    pdReq = 1'b1; step(20);
    pdReq = 1'b0; step(40);
    check("R2 aborted stays low", 8'(pdSignal), 8'd0);
    pdReq = 1'b1;
    step(DELAY - 1);
    check("R2 reload low", 8'(pdSignal), 8'd0);
    step(1);
    check("R2 reload high", 8'(pdSignal), 8'd1);
    settle();
  endtask

  task automatic tOffAndWake();
    busPresent = 1'b0; batPresent = 1'b1; switchOff = 1'b1; step(4);
    pdReq = 1'b1; step(DELAY);
    check("R4 off mode", 8'({offState, standby, convEn, convBypass}), 8'b1000);
    busPresent = 1'b1; step(2);
    check("R8 still off", 8'({offState, pdSignal}), 8'b11);
    step(1);
    check("R8 bus wake", 8'({offState, pdSignal}), 8'b00);
    settle();
    busPresent = 1'b0; step(4);
    pdReq = 1'b1; step(DELAY);
    check("R4 off again", 8'(offState), 8'd1);
    switchOff = 1'b0; step(2);
    check("R8 switch not yet", 8'(offState), 8'd1);
    step(1);
    check("R8 switch wake", 8'({offState, pdSignal}), 8'b00);
    settle();
  endtask

  task automatic tTiedLow();
    busPresent = 1'b0; batPresent = 1'b1; switchOff = 1'b0; step(4);
    pdReq = 1'b1; step(DELAY);
    check("R10 tied low standby", 8'({standby, offState, convEn}), 8'b101);
    settle();
  endtask

  task automatic tSource();
    busPresent = 1'b1; batPresent = 1'b1; auxPresent = 1'b1; step(1);
    busPresent = 1'b0; step(1);
    check("R5 sync lag", 8'(srcSel), 8'b01);
    step(1);
    check("R5 battery", 8'(srcSel), 8'b10);
    check("R12 run kept", 8'({pdSignal, convEn}), 8'b01);
    batPresent = 1'b0; step(2);
    check("R5 aux", 8'(srcSel), 8'b11);
    auxPresent = 1'b0; step(2);
    check("R5 none", 8'(srcSel), 8'b00);
    busPresent = 1'b1; batPresent = 1'b1; step(2);
    check("R5 bus over battery", 8'(srcSel), 8'b01);
    busPresent = 1'b0; step(2);
    check("R12 bus removed", 8'({srcSel, convEn, standby, offState}), 8'b10100);
  endtask

  task automatic tBypass();
    busPresent = 1'b1; cardSupplyReq = 1'b0; step(2);
    check("R6 bypass on", 8'(convBypass), 8'd1);
    cardSupplyReq = 1'b1; step(1);
    check("R6 card demand", 8'(convBypass), 8'd0);
    cardSupplyReq = 1'b0; busPresent = 1'b0; batPresent = 1'b1; step(2);
    check("R6 battery no bypass", 8'(convBypass), 8'd0);
  endtask

  task automatic tPeriph();
    busPresent = 1'b1; step(4);
    periphCtl = 5'b10110; step(1);
    check("R7 follow", 8'(periphEn), 8'b10110);
    periphCtl = 5'b01001; step(1);
    check("R7 follow 2", 8'(periphEn), 8'b01001);
    periphCtl = 5'b11111;
    pdReq = 1'b1; step(DELAY - 1);
    check("R7 before pd", 8'(periphEn), 8'b11111);
    step(1);
    check("R7 forced off", 8'(periphEn), 8'd0);
    settle();
    check("R7 restored", 8'(periphEn), 8'b11111);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    tReset();
    tDelay();
    tAbort();
    tOffAndWake();
    tTiedLow();
    tSource();
    tBypass();
    tPeriph();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule